// File: doc/BRIEF.md
# Monochrome Stream Expansion Unit

This block turns a stream of 1-bit-per-pixel bitmap words into 32-bit colour pixels covering a rectangle of programmable width and height. Each 32-bit input word is taken on a valid/ready handshake. It is cut into row slices according to a packing mode. Every bit is then replaced by a foreground colour (bit 1) or a background colour (bit 0). The result leaves as one pixel per cycle with its x/y position, a transparency flag and a marker on the final pixel of the rectangle.

A job begins with a start pulse, which captures size, packing mode, both colours and the transparency polarity. The rectangle is walked in horizontal bands whose height is the number of rows one word covers. Within a band the words run from left to right, and the bands run from top to bottom. Each word gives out its own pixels before the next word is taken. A one-cycle done pulse closes the job.

Top module: `mono_expand`

## Requirements
- R1: After reset, out_valid, in_ready and done are all low.
- R2: With cfg_pack = 0, one word covers 4 rows of 8 pixels. Bits 31:24 are the top row, 23:16 the next, 15:8 the third and 7:0 the bottom row. In each row the most significant bit is the leftmost pixel.
- R3: With cfg_pack = 1, one word covers 2 rows of 16 pixels. Bits 31:16 are the upper row and 15:0 the lower row, most significant bit leftmost.
- R4: With cfg_pack = 2 or 3, one word covers one row segment of up to 32 pixels, starting at bit 31. Each row starts on a fresh word, and bits beyond the rectangle's right edge are dropped.
- R5: A band is as tall as the rows one word covers. Words run left to right inside a band, and bands run top to bottom. Pixels that fall outside the width or height are skipped without any output cycle. The out_x and out_y outputs give each pixel's column and row.
- R6: A bit of 1 produces cfg_fg and a bit of 0 produces cfg_bg on out_color, each passed through unchanged as 32 bits (alpha 31:24, red 23:16, green 15:8, blue 7:0).
- R7: When cfg_key_one is 1, pixels whose bit is 1 have out_transp high. When cfg_key_one is 0, pixels whose bit is 0 have out_transp high. All other pixels have out_transp low.
- R8: out_last is high only on the final pixel of the rectangle. done is high for exactly the one cycle after that pixel's handshake, and in_ready is low from then on until the next start.
- R9: While out_valid is high and out_ready is low, the pixel outputs hold stable. in_ready is high only when no pixel is pending, or when the pending pixel is the last of its word and is being accepted.
- R10: Only the start pulse captures the configuration. Changes on the cfg inputs during a job have no effect. A start during a job is ignored. A start with zero width or zero height begins no job.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job and capture the configuration |
| cfg_width | input | COORD_W | Rectangle width in pixels |
| cfg_height | input | COORD_W | Rectangle height in pixels |
| cfg_pack | input | 2 | Packing mode: 0 = 8 px, 1 = 16 px, 2 = 32 px, 3 = unpacked |
| cfg_fg | input | 32 | Colour for bit value 1 |
| cfg_bg | input | 32 | Colour for bit value 0 |
| cfg_key_one | input | 1 | 1: bit 1 is transparent; 0: bit 0 is transparent |
| in_valid | input | 1 | Bitmap word valid |
| in_data | input | 32 | Bitmap word |
| in_ready | output | 1 | Bitmap word accepted when high with in_valid |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_color | output | 32 | Pixel colour |
| out_x | output | COORD_W | Pixel column |
| out_y | output | COORD_W | Pixel row |
| out_transp | output | 1 | Pixel is transparent |
| out_last | output | 1 | Final pixel of the rectangle |
| done | output | 1 | One-cycle pulse after the final pixel |

## Verification
A wrong slice or column counter shows up at once as a wrong colour or coordinate on the next pixel. A wrong band or word-origin counter shows up at the first word boundary, as a jump in out_x or out_y. A miscounted end of rectangle shows up on the final pixel: out_last or done comes early, comes late or never arrives, and the pixel queue ends up too short or too long. Stalls and restarts during a job check that the held outputs and the captured configuration stay fixed over many cycles.

// File: rtl/mx_pkg.sv
package mx_pkg;

   typedef enum logic [1:0] {
      MX_PACK8  = 2'd0,
      MX_PACK16 = 2'd1,
      MX_PACK32 = 2'd2,
      MX_RAW    = 2'd3
   } mx_pack_e;

   // log2 of the pixels one row slice holds
   function automatic logic [2:0] slice_lg(input mx_pack_e m);
      case (m)
         MX_PACK8:  return 3'd3;
         MX_PACK16: return 3'd4;
         default:   return 3'd5;
      endcase
   endfunction

   // row slices held by one word
   function automatic logic [2:0] slice_rows(input mx_pack_e m);
      case (m)
         MX_PACK8:  return 3'd4;
         MX_PACK16: return 3'd2;
         default:   return 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/mx_cfg.sv
module mx_cfg
   import mx_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int COLOR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [COORD_W-1:0] width_i,
   input  logic [COORD_W-1:0] height_i,
   input  logic [1:0]         pack_i,
   input  logic [COLOR_W-1:0] fg_i,
   input  logic [COLOR_W-1:0] bg_i,
   input  logic               key_one_i,
   output logic [COORD_W-1:0] width_q,
   output logic [COORD_W-1:0] height_q,
   output mx_pack_e           pack_q,
   output logic [COLOR_W-1:0] fg_q,
   output logic [COLOR_W-1:0] bg_q,
   output logic               key_one_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width_q   <= '0;
         height_q  <= '0;
         pack_q    <= MX_PACK8;
         fg_q      <= '0;
         bg_q      <= '0;
         key_one_q <= 1'b0;
      end else if (load) begin
         width_q   <= width_i;
         height_q  <= height_i;
         pack_q    <= mx_pack_e'(pack_i);
         fg_q      <= fg_i;
         bg_q      <= bg_i;
         key_one_q <= key_one_i;
      end
   end

endmodule

// File: rtl/mx_walker.sv
module mx_walker
   import mx_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int WORD_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [COORD_W-1:0] width,
   input  logic [COORD_W-1:0] height,
   input  mx_pack_e           pack,
   input  logic               in_valid,
   input  logic [WORD_W-1:0]  in_data,
   output logic               in_ready,
   output logic               pix_valid,
   input  logic               pix_ready,
   output logic               pix_bit,
   output logic [COORD_W-1:0] pix_x,
   output logic [COORD_W-1:0] pix_y,
   output logic               pix_last,
   output logic               done,
   output logic               active
);

   localparam int IDX_W = $clog2(WORD_W);

   logic [WORD_W-1:0]  word_q;
   logic               have_q, active_q, done_q;
   logic [IDX_W-1:0]   c_q;
   logic [1:0]         r_q;
   logic [COORD_W-1:0] x0_q, y0_q;

   logic [2:0]         lg, rows;
   logic [IDX_W-1:0]   cmax;
   logic [COORD_W:0]   x0_nxt, y0_nxt;
   logic               slice_end, word_end, band_done, last_band, rect_last;
   logic               fire, take;
   logic [IDX_W:0]     bit_off;

   assign lg        = slice_lg(pack);
   assign rows      = slice_rows(pack);
   assign cmax      = IDX_W'((1 << lg) - 1);
   assign pix_x     = x0_q + COORD_W'(c_q);
   assign pix_y     = y0_q + COORD_W'(r_q);
   assign slice_end = (c_q == cmax) || (pix_x == width - 1'b1);
   assign word_end  = slice_end && ((r_q == 2'(rows - 3'd1)) || (pix_y == height - 1'b1));
   assign x0_nxt    = {1'b0, x0_q} + (COORD_W+1)'(1 << lg);
   assign y0_nxt    = {1'b0, y0_q} + (COORD_W+1)'(rows);
   assign band_done = x0_nxt >= {1'b0, width};
   assign last_band = y0_nxt >= {1'b0, height};
   assign rect_last = word_end && band_done && last_band;
   assign bit_off   = ((IDX_W+1)'(r_q) << lg) + (IDX_W+1)'(c_q);
   assign pix_bit   = word_q[IDX_W'(WORD_W - 1) - bit_off[IDX_W-1:0]];

   assign pix_valid = have_q;
   assign pix_last  = have_q && rect_last;
   assign done      = done_q;
   assign active    = active_q;
   assign fire      = have_q && pix_ready;
   assign in_ready  = active_q && (!have_q || (word_end && pix_ready && !rect_last));
   assign take      = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q   <= '0;
         have_q   <= 1'b0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
         c_q      <= '0;
         r_q      <= '0;
         x0_q     <= '0;
         y0_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            active_q <= 1'b1;
            have_q   <= 1'b0;
            c_q      <= '0;
            r_q      <= '0;
            x0_q     <= '0;
            y0_q     <= '0;
         end else begin
            if (fire) begin
               if (!slice_end) begin
                  c_q <= c_q + 1'b1;
               end else begin
                  c_q <= '0;
                  if (!word_end) begin
                     r_q <= r_q + 1'b1;
                  end else begin
                     r_q    <= '0;
                     have_q <= 1'b0;
                     if (band_done) begin
                        x0_q <= '0;
                        y0_q <= y0_nxt[COORD_W-1:0];
                     end else begin
                        x0_q <= x0_nxt[COORD_W-1:0];
                     end
                     if (rect_last) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                     end
                  end
               end
            end
            if (take) begin
               word_q <= in_data;
               have_q <= 1'b1;
            end
         end
      end
   end

   assert_coord_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      have_q |-> (pix_x < width && pix_y < height));

   assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && !pix_ready) |=> (have_q && $stable(pix_x) && $stable(pix_y) && $stable(pix_bit)));

   assert_ready_not_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!have_q || pix_ready));

   assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pix_last) |=> (done_q && !active_q && !in_ready));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/mx_colour.sv
module mx_colour #(
   parameter int COLOR_W = 32
) (
   input  logic               bit_i,
   input  logic [COLOR_W-1:0] fg,
   input  logic [COLOR_W-1:0] bg,
   input  logic               key_one,
   output logic [COLOR_W-1:0] color,
   output logic               transp
);

   assign color  = bit_i ? fg : bg;
   assign transp = (bit_i == key_one);

endmodule

// File: rtl/mono_expand.sv
module mono_expand
   import mx_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int WORD_W  = 32,
   parameter int COLOR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [COORD_W-1:0] cfg_width,
   input  logic [COORD_W-1:0] cfg_height,
   input  logic [1:0]         cfg_pack,
   input  logic [COLOR_W-1:0] cfg_fg,
   input  logic [COLOR_W-1:0] cfg_bg,
   input  logic               cfg_key_one,
   input  logic               in_valid,
   input  logic [WORD_W-1:0]  in_data,
   output logic               in_ready,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [COLOR_W-1:0] out_color,
   output logic [COORD_W-1:0] out_x,
   output logic [COORD_W-1:0] out_y,
   output logic               out_transp,
   output logic               out_last,
   output logic               done
);

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("mono_expand: WORD_W must be 32");
      end
      if (COORD_W < 6 || COORD_W > 16) begin : g_bad_coord
         $error("mono_expand: COORD_W must be 6..16");
      end
      if (COLOR_W != 32) begin : g_bad_color
         $error("mono_expand: COLOR_W must be 32");
      end
   endgenerate

   logic               active, start_ok, pix_bit;
   logic [COORD_W-1:0] width_q, height_q;
   mx_pack_e           pack_q;
   logic [COLOR_W-1:0] fg_q, bg_q;
   logic               key_one_q;

   assign start_ok = start && !active && (cfg_width != '0) && (cfg_height != '0);

   mx_cfg #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(start_ok),
      .width_i(cfg_width), .height_i(cfg_height), .pack_i(cfg_pack),
      .fg_i(cfg_fg), .bg_i(cfg_bg), .key_one_i(cfg_key_one),
      .width_q(width_q), .height_q(height_q), .pack_q(pack_q),
      .fg_q(fg_q), .bg_q(bg_q), .key_one_q(key_one_q)
   );

   mx_walker #(.COORD_W(COORD_W), .WORD_W(WORD_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .go(start_ok),
      .width(width_q), .height(height_q), .pack(pack_q),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .pix_valid(out_valid), .pix_ready(out_ready), .pix_bit(pix_bit),
      .pix_x(out_x), .pix_y(out_y), .pix_last(out_last),
      .done(done), .active(active)
   );

   mx_colour #(.COLOR_W(COLOR_W)) u_col (
      .bit_i(pix_bit), .fg(fg_q), .bg(bg_q), .key_one(key_one_q),
      .color(out_color), .transp(out_transp)
   );

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> ($stable(width_q) && $stable(height_q) && $stable(fg_q) && $stable(bg_q)));

   assert_colour_choice_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_color == fg_q || out_color == bg_q));

endmodule

// File: tb/mono_expand_test.sv
module mono_expand_test;

   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] cfg_width = '0, cfg_height = '0;
   logic [1:0]    cfg_pack = '0;
   logic [31:0]   cfg_fg = '0, cfg_bg = '0;
   logic          cfg_key_one = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   in_data = '0;
   logic          in_ready;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [31:0]   out_color;
   logic [CW-1:0] out_x, out_y;
   logic          out_transp, out_last, done;

   always #10 clk = ~clk;

   mono_expand #(.COORD_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_pack(cfg_pack),
      .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .cfg_key_one(cfg_key_one),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_color(out_color),
      .out_x(out_x), .out_y(out_y), .out_transp(out_transp),
      .out_last(out_last), .done(done)
   );

   typedef struct packed {
      logic [31:0]   color;
      logic [CW-1:0] x;
      logic [CW-1:0] y;
      logic          tr;
      logic          last;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] words[0:63];
   int          n_words;
   int          checks = 0;
   int          errors = 0;
   int          jobs_done = 0;
   int          stall_mode = 0;
   int          cyc = 0;
   string       cur_tag = "R2";
   bit          want_done = 0;
   bit          stalled = 0;
   exp_t        held;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // downstream ready pattern
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      if (stall_mode == 0) out_ready = 1'b1;
      else out_ready = (cyc % 3) != 0;
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (want_done) begin
            want_done = 0;
            check(done == 1'b1, "R8", "done pulse", done, 1);
            check(in_ready == 1'b0, "R8", "in_ready after done", in_ready, 0);
            jobs_done++;
         end else if (done) begin
            check(1'b0, "R8", "unexpected done", done, 0);
         end
         if (stalled) begin
            check(out_valid && out_color == held.color && out_x == held.x &&
                  out_y == held.y && out_transp == held.tr, "R9", "held on stall",
                  {out_color, out_x}, {held.color, held.x});
         end
         stalled = 0;
         if (out_valid && !out_ready) begin
            stalled = 1;
            held = '{color: out_color, x: out_x, y: out_y, tr: out_transp, last: out_last};
         end
         if (in_ready && out_valid && !out_ready)
            check(1'b0, "R9", "in_ready while stalled", in_ready, 0);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, cur_tag, "extra pixel", out_x, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(out_color == e.color, "R6", "colour", out_color, e.color);
               check(out_x == e.x && out_y == e.y, cur_tag, "coord x,y",
                     {out_x, out_y}, {e.x, e.y});
               check(out_transp == e.tr, "R7", "transparency", out_transp, e.tr);
               check(out_last == e.last, "R8", "last flag", out_last, e.last);
               if (e.last) want_done = 1;
            end
         end
      end
   end

   task automatic build(input int w, input int h, input int mode, input bit key,
                        input logic [31:0] fg, input logic [31:0] bg, input int seed);
      int g, rr, k;
      exp_t e;
      g  = (mode == 0) ? 8 : (mode == 1) ? 16 : 32;
      rr = 32 / g;
      k  = 0;
      for (int b = 0; b * rr < h; b++) begin
         for (int wx = 0; wx * g < w; wx++) begin
            logic [31:0] wd;
            wd = (seed * 32'h9E37_79B1) ^ (k * 32'h0101_7F3D) ^ 32'h5A3C_96E1;
            words[k] = wd;
            k++;
            for (int r = 0; r < rr; r++) begin
               for (int c = 0; c < g; c++) begin
                  int x, y;
                  logic bv;
                  x = wx * g + c;
                  y = b * rr + r;
                  if (x < w && y < h) begin
                     bv = wd[31 - r * g - c];
                     e.color = bv ? fg : bg;
                     e.x = CW'(x);
                     e.y = CW'(y);
                     e.tr = (bv == key);
                     e.last = 1'b0;
                     exp_q.push_back(e);
                  end
               end
            end
         end
      end
      e = exp_q.pop_back();
      e.last = 1'b1;
      exp_q.push_back(e);
      n_words = k;
   endtask

   task automatic send_word(input logic [31:0] wd);
      in_valid = 1'b1;
      in_data  = wd;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic run_job(input string tag, input int w, input int h, input int mode,
                          input bit key, input logic [31:0] fg, input logic [31:0] bg,
                          input int seed, input int stall);
      int target;
      cur_tag    = tag;
      stall_mode = stall;
      build(w, h, mode, key, fg, bg, seed);
      target = jobs_done + 1;
      @(posedge clk); #1;
      cfg_width = CW'(w); cfg_height = CW'(h); cfg_pack = 2'(mode);
      cfg_fg = fg; cfg_bg = bg; cfg_key_one = key;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      // R10: inputs changed and a second start during the job must have no effect
      cfg_width = 1; cfg_height = 1; cfg_pack = ~cfg_pack;
      cfg_fg = ~fg; cfg_bg = ~bg; cfg_key_one = ~key;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      for (int i = 0; i < n_words; i++) send_word(words[i]);
      while (jobs_done < target) @(negedge clk);
      check(exp_q.size() == 0, tag, "pixels missing", exp_q.size(), 0);
      check(exp_q.size() == 0, "R10", "config held through job", exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 0 && in_ready == 0 && done == 0, "R1", "reset state",
            {out_valid, in_ready, done}, 0);

      run_job("R2", 8, 4, 0, 1'b1, 32'hFF11_2233, 32'h8044_5566, 1, 0);
      run_job("R5", 13, 6, 0, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 2, 1);
      run_job("R3", 20, 3, 1, 1'b0, 32'hAA00_FF00, 32'h00FF_00AA, 3, 0);
      run_job("R4", 40, 2, 3, 1'b0, 32'hC0C0_C0C0, 32'h0303_0303, 4, 1);
      run_job("R4", 32, 1, 2, 1'b1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 5, 1);
      run_job("R7", 5, 7, 1, 1'b1, 32'h7777_0000, 32'h0000_7777, 6, 0);

      // R10: zero width starts nothing
      stall_mode = 0;
      @(posedge clk); #1;
      cfg_width = 0; cfg_height = 4; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      in_valid = 1'b1; in_data = 32'hFFFF_FFFF;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(in_ready == 0 && out_valid == 0, "R10", "zero size idle",
               {in_ready, out_valid}, 0);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule